// File: doc/BRIEF.md
# Hart Debug Mode Entry and Exit Controller

This block is the hart-side control that moves a hart into and out of debug mode. A halt request from the debug module is taken like a special interrupt. When it arrives, or when an ebreak retires in normal mode, the controller stores the interrupted PC in a debug PC register. It also stores the entry cause and the privilege level the hart was running at in a debug control/status register. It then issues a redirect to the debug entry address in debug-module memory, where the park loop runs in machine mode.

While the hart is in debug mode, the block works as follows:
- An exception sends the hart to a separate debug exception address, and the saved state is left untouched.
- An ebreak sends the hart back to the park loop.
- Halt requests and normal interrupts have no effect.
- A retiring dret sends the hart back to the saved PC at the saved privilege, and debug mode ends.

The pipeline reports retire and exception events as single-cycle inputs and consumes the registered redirect one cycle later.

Top module: `hart_dbg_ctrl`

## Requirements
- R1: After synchronous reset, debug_mode_o is 0, dpc_o equals parameter DPC_RESET, dcsr_cause_o is 0, dcsr_prv_o is 3 (machine mode), and redirect_valid_o is 0.
- R2: halt_req_i high while not in debug mode causes, on the next cycle, debug_mode_o=1, dpc_o equal to the sampled pc_i, dcsr_cause_o=3, dcsr_prv_o equal to the sampled prv_i, and a redirect to DBG_BASE with redirect_prv_o=3.
- R3: ebreak_i high while not in debug mode enters debug the same way but with dcsr_cause_o=1. When halt_req_i and ebreak_i are both high, cause 3 wins.
- R4: exc_i high while in debug mode produces a redirect to DBG_EXC with redirect_prv_o=3. The block stays in debug mode, and dpc_o, dcsr_cause_o and dcsr_prv_o are unchanged.
- R5: ebreak_i while in debug mode (without exc_i or dret_i) produces a redirect to DBG_BASE and changes no debug state.
- R6: dret_i while in debug mode (without exc_i) leaves debug mode on the next cycle and redirects to dpc_o with redirect_prv_o equal to dcsr_prv_o.
- R7: halt_req_i while in debug mode is ignored. With no other event it produces no redirect and no state change.
- R8: irq_take_o is 1 exactly when irq_i is 1, the hart is not in debug mode, and halt_req_i is 0.
- R9: Inside debug mode the event priority is exc_i, then dret_i, then ebreak_i.
- R10: exc_i outside debug mode has no effect on any output of this block.
- R11: redirect_valid_o is high for exactly one cycle after each accepted event and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req_i | input | 1 | Debug halt request |
| ebreak_i | input | 1 | An ebreak retired this cycle |
| exc_i | input | 1 | An exception was raised this cycle |
| dret_i | input | 1 | A dret retired this cycle |
| irq_i | input | 1 | A normal interrupt is pending |
| pc_i | input | XLEN | PC of the current instruction |
| prv_i | input | 2 | Current privilege level |
| irq_take_o | output | 1 | Normal interrupt may be taken |
| redirect_valid_o | output | 1 | Redirect the fetch stage |
| redirect_pc_o | output | XLEN | Redirect target |
| redirect_prv_o | output | 2 | Privilege to apply with the redirect |
| debug_mode_o | output | 1 | Hart is in debug mode |
| dpc_o | output | XLEN | Saved debug PC |
| dcsr_cause_o | output | 3 | Saved entry cause |
| dcsr_prv_o | output | 2 | Saved privilege |

## Verification
The assertions check several properties on every cycle:
- At most one event is accepted at a time.
- A rise of debug mode always comes with a redirect to the entry address in machine mode.
- The saved PC and cause never move while debug mode is held.
- A fall of debug mode always redirects to the saved PC at the saved privilege.
- Interrupts are never granted inside debug mode.

Only the bench's scenarios can show the rest: the exact PC and privilege captured at entry, the priority between simultaneous events, and the fact that ignored requests and out-of-mode exceptions leave every output unchanged.

// File: rtl/hdm_pkg.sv
package hdm_pkg;

    typedef logic [1:0] prv_t;
    localparam prv_t PRV_MACHINE = 2'd3;

    typedef enum logic [2:0] {
        CAUSE_NONE   = 3'd0,
        CAUSE_EBREAK = 3'd1,
        CAUSE_HALT   = 3'd3
    } cause_e;

    typedef enum logic [2:0] {
        EV_NONE       = 3'd0,
        EV_ENTER_HALT = 3'd1,
        EV_ENTER_EBRK = 3'd2,
        EV_DBG_EXC    = 3'd3,
        EV_PARK       = 3'd4,
        EV_DRET       = 3'd5
    } ev_e;

    typedef struct packed {
        cause_e cause;
        prv_t   prv;
    } dcsr_t;

    function automatic logic ev_is_entry(ev_e e);
        return (e == EV_ENTER_HALT) || (e == EV_ENTER_EBRK);
    endfunction

    function automatic cause_e ev_cause(ev_e e);
        case (e)
            EV_ENTER_HALT: return CAUSE_HALT;
            EV_ENTER_EBRK: return CAUSE_EBREAK;
            default:       return CAUSE_NONE;
        endcase
    endfunction

endpackage

// File: rtl/hdm_arbiter.sv
module hdm_arbiter
    import hdm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_debug,
    input  logic halt_req,
    input  logic ebreak,
    input  logic exc,
    input  logic dret,
    input  logic irq,
    output ev_e  ev,
    output logic irq_take
);

    always_comb begin
        ev = EV_NONE;
        if (!in_debug) begin
            // Normal mode: halt outranks ebreak; exceptions and dret are not ours.
            if (halt_req)    ev = EV_ENTER_HALT;
            else if (ebreak) ev = EV_ENTER_EBRK;
        end else begin
            // Debug mode: exception, then dret, then ebreak.
            if (exc)         ev = EV_DBG_EXC;
            else if (dret)   ev = EV_DRET;
            else if (ebreak) ev = EV_PARK;
        end
    end

    assign irq_take = irq && !in_debug && !halt_req;

    a_r7_no_entry_in_debug: assert property (@(posedge clk) disable iff (rst)
        in_debug |-> !ev_is_entry(ev));

    a_r9_exc_first: assert property (@(posedge clk) disable iff (rst)
        (in_debug && exc) |-> (ev == EV_DBG_EXC));

    a_r10_exc_ignored_outside: assert property (@(posedge clk) disable iff (rst)
        (!in_debug && !halt_req && !ebreak) |-> (ev == EV_NONE));

endmodule

// File: rtl/hdm_state.sv
module hdm_state
    import hdm_pkg::*;
#(
    parameter int unsigned     XLEN      = 32,
    parameter logic [XLEN-1:0] DPC_RESET = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  ev_e             ev,
    input  logic [XLEN-1:0] pc_i,
    input  prv_t            prv_i,
    output logic            debug_mode,
    output logic [XLEN-1:0] dpc,
    output dcsr_t           dcsr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            debug_mode <= 1'b0;
            dpc        <= DPC_RESET;
            dcsr.cause <= CAUSE_NONE;
            dcsr.prv   <= PRV_MACHINE;
        end else if (ev_is_entry(ev)) begin
            debug_mode <= 1'b1;
            dpc        <= pc_i;
            dcsr.cause <= ev_cause(ev);
            dcsr.prv   <= prv_i;
        end else if (ev == EV_DRET) begin
            debug_mode <= 1'b0;
        end
    end

    a_r4_dpc_held: assert property (@(posedge clk) disable iff (rst)
        ($past(debug_mode) && debug_mode) |-> ($stable(dpc) && $stable(dcsr)));

endmodule

// File: rtl/hdm_redirect.sv
module hdm_redirect
    import hdm_pkg::*;
#(
    parameter int unsigned     XLEN     = 32,
    parameter logic [XLEN-1:0] DBG_BASE = '0,
    parameter logic [XLEN-1:0] DBG_EXC  = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  ev_e             ev,
    input  logic [XLEN-1:0] dpc,
    input  prv_t            saved_prv,
    output logic            valid,
    output logic [XLEN-1:0] pc,
    output prv_t            prv
);

    logic [XLEN-1:0] tgt_pc;
    prv_t            tgt_prv;

    always_comb begin
        tgt_pc  = DBG_BASE;
        tgt_prv = PRV_MACHINE;
        case (ev)
            EV_DBG_EXC: tgt_pc = DBG_EXC;
            EV_DRET: begin
                tgt_pc  = dpc;
                tgt_prv = saved_prv;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            pc    <= '0;
            prv   <= PRV_MACHINE;
        end else begin
            valid <= (ev != EV_NONE);
            if (ev != EV_NONE) begin
                pc  <= tgt_pc;
                prv <= tgt_prv;
            end
        end
    end

    a_r11_valid_follows_event: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_NONE) |=> !valid);

endmodule

// File: rtl/hart_dbg_ctrl.sv
module hart_dbg_ctrl
    import hdm_pkg::*;
#(
    parameter int unsigned     XLEN      = 32,
    parameter logic [XLEN-1:0] DBG_BASE  = 32'h0000_0800,
    parameter logic [XLEN-1:0] DBG_EXC   = 32'h0000_0808,
    parameter logic [XLEN-1:0] DPC_RESET = 32'h0000_0000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            halt_req_i,
    input  logic            ebreak_i,
    input  logic            exc_i,
    input  logic            dret_i,
    input  logic            irq_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [1:0]      prv_i,
    output logic            irq_take_o,
    output logic            redirect_valid_o,
    output logic [XLEN-1:0] redirect_pc_o,
    output logic [1:0]      redirect_prv_o,
    output logic            debug_mode_o,
    output logic [XLEN-1:0] dpc_o,
    output logic [2:0]      dcsr_cause_o,
    output logic [1:0]      dcsr_prv_o
);

    ev_e             ev;
    logic            dbg_q;
    logic [XLEN-1:0] dpc_q;
    dcsr_t           dcsr_q;

    hdm_arbiter u_arb (
        .clk      (clk),
        .rst      (rst),
        .in_debug (dbg_q),
        .halt_req (halt_req_i),
        .ebreak   (ebreak_i),
        .exc      (exc_i),
        .dret     (dret_i),
        .irq      (irq_i),
        .ev       (ev),
        .irq_take (irq_take_o)
    );

    hdm_state #(.XLEN(XLEN), .DPC_RESET(DPC_RESET)) u_state (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .pc_i       (pc_i),
        .prv_i      (prv_i),
        .debug_mode (dbg_q),
        .dpc        (dpc_q),
        .dcsr       (dcsr_q)
    );

    hdm_redirect #(.XLEN(XLEN), .DBG_BASE(DBG_BASE), .DBG_EXC(DBG_EXC)) u_redir (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .dpc       (dpc_q),
        .saved_prv (dcsr_q.prv),
        .valid     (redirect_valid_o),
        .pc        (redirect_pc_o),
        .prv       (redirect_prv_o)
    );

    assign debug_mode_o = dbg_q;
    assign dpc_o        = dpc_q;
    assign dcsr_cause_o = dcsr_q.cause;
    assign dcsr_prv_o   = dcsr_q.prv;

    a_r2_entry_redirect: assert property (@(posedge clk) disable iff (rst)
        $rose(debug_mode_o) |-> (redirect_valid_o && redirect_pc_o == DBG_BASE
                                 && redirect_prv_o == PRV_MACHINE));

    a_r6_exit_redirect: assert property (@(posedge clk) disable iff (rst)
        $fell(debug_mode_o) |-> (redirect_valid_o && redirect_pc_o == dpc_o
                                 && redirect_prv_o == dcsr_prv_o));

    a_r8_no_irq_in_debug: assert property (@(posedge clk) disable iff (rst)
        debug_mode_o |-> !irq_take_o);

    a_r2_cause_on_entry: assert property (@(posedge clk) disable iff (rst)
        $rose(debug_mode_o) |-> (dcsr_cause_o == 3'd3 || dcsr_cause_o == 3'd1));

endmodule

// File: tb/hart_dbg_ctrl_tb.sv
module hart_dbg_ctrl_tb;

    localparam int unsigned XLEN = 32;
    localparam logic [31:0] BASE = 32'h0000_0800;
    localparam logic [31:0] EXCA = 32'h0000_0808;
    localparam logic [31:0] DRST = 32'h0000_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic halt_req_i = 0, ebreak_i = 0, exc_i = 0, dret_i = 0, irq_i = 0;
    logic [31:0] pc_i = '0;
    logic [1:0]  prv_i = '0;
    logic        irq_take_o, redirect_valid_o, debug_mode_o;
    logic [31:0] redirect_pc_o, dpc_o;
    logic [1:0]  redirect_prv_o, dcsr_prv_o;
    logic [2:0]  dcsr_cause_o;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference state computed from the requirements
    logic        m_dbg;
    logic [31:0] m_dpc;
    logic [2:0]  m_cause;
    logic [1:0]  m_prv;
    logic        m_rv;
    logic [31:0] m_rpc;
    logic [1:0]  m_rprv;

    always #5 clk = ~clk;

    hart_dbg_ctrl #(.XLEN(XLEN), .DBG_BASE(BASE), .DBG_EXC(EXCA), .DPC_RESET(DRST)) u_dut (
        .clk(clk), .rst(rst), .halt_req_i(halt_req_i), .ebreak_i(ebreak_i),
        .exc_i(exc_i), .dret_i(dret_i), .irq_i(irq_i), .pc_i(pc_i), .prv_i(prv_i),
        .irq_take_o(irq_take_o), .redirect_valid_o(redirect_valid_o),
        .redirect_pc_o(redirect_pc_o), .redirect_prv_o(redirect_prv_o),
        .debug_mode_o(debug_mode_o), .dpc_o(dpc_o), .dcsr_cause_o(dcsr_cause_o),
        .dcsr_prv_o(dcsr_prv_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_irq(input logic irq, input logic dbg, input logic halt);
        return irq && !dbg && !halt;
    endfunction

    // Advance the model by one clock using the inputs currently driven (R2-R7, R9-R11)
    task automatic model_step();
        m_rv = 1'b0;
        if (!m_dbg) begin
            if (halt_req_i || ebreak_i) begin
                m_dbg = 1; m_dpc = pc_i; m_prv = prv_i;
                m_cause = halt_req_i ? 3'd3 : 3'd1;
                m_rv = 1; m_rpc = BASE; m_rprv = 2'd3;
            end
        end else begin
            if (exc_i) begin
                m_rv = 1; m_rpc = EXCA; m_rprv = 2'd3;
            end else if (dret_i) begin
                m_rv = 1; m_rpc = m_dpc; m_rprv = m_prv; m_dbg = 0;
            end else if (ebreak_i) begin
                m_rv = 1; m_rpc = BASE; m_rprv = 2'd3;
            end
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "debug_mode", {31'd0, debug_mode_o}, {31'd0, m_dbg});
        chk(req, "dpc", dpc_o, m_dpc);
        chk(req, "cause", {29'd0, dcsr_cause_o}, {29'd0, m_cause});
        chk(req, "dcsr_prv", {30'd0, dcsr_prv_o}, {30'd0, m_prv});
        chk(req, "redirect_valid", {31'd0, redirect_valid_o}, {31'd0, m_rv});
        if (m_rv) begin
            chk(req, "redirect_pc", redirect_pc_o, m_rpc);
            chk(req, "redirect_prv", {30'd0, redirect_prv_o}, {30'd0, m_rprv});
        end
    endtask

    // Drive one cycle at the falling edge, check irq_take, clock, check registers
    task automatic cyc(input string req, input logic h, input logic e, input logic x,
                       input logic d, input logic i, input logic [31:0] pc,
                       input logic [1:0] p);
        halt_req_i = h; ebreak_i = e; exc_i = x; dret_i = d; irq_i = i;
        pc_i = pc; prv_i = p;
        #1;
        chk("R8", "irq_take", {31'd0, irq_take_o}, {31'd0, exp_irq(i, m_dbg, h)});
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_all(req);
    endtask

    initial begin : watchdog
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog timeout actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        m_dbg = 0; m_dpc = DRST; m_cause = 0; m_prv = 2'd3;
        m_rv = 0; m_rpc = '0; m_rprv = 2'd3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        check_all("R1");

        // R10: exception outside debug mode changes nothing
        cyc("R10", 0, 0, 1, 0, 1, 32'h1000, 2'd0);
        // R2: halt entry from user mode
        cyc("R2", 1, 0, 0, 0, 1, 32'h1234_5678, 2'd0);
        // R7: halt while in debug is ignored
        cyc("R7", 1, 0, 0, 0, 1, 32'hdead_0000, 2'd1);
        // R4: exception in debug
        cyc("R4", 0, 0, 1, 0, 0, 32'h0000_0810, 2'd3);
        // R5: ebreak in debug returns to park loop
        cyc("R5", 0, 1, 0, 0, 0, 32'h0000_0814, 2'd3);
        // R9: exc beats dret
        cyc("R9", 0, 1, 1, 1, 0, 32'h0000_0818, 2'd3);
        // R6/R9: dret beats ebreak, restores PC and privilege
        cyc("R6", 0, 1, 0, 1, 0, 32'h0000_081c, 2'd3);
        // R11: idle cycle drops redirect
        cyc("R11", 0, 0, 0, 0, 0, 32'h1234_567c, 2'd0);
        // R3: both halt and ebreak -> halt cause
        cyc("R3", 1, 1, 0, 0, 0, 32'h2000, 2'd1);
        cyc("R6", 0, 0, 0, 1, 0, 32'h0, 2'd3);
        // R3: ebreak alone
        cyc("R3", 0, 1, 0, 0, 0, 32'h3000, 2'd2);
        cyc("R6", 0, 0, 0, 1, 0, 32'h0, 2'd3);

        // Constrained random
        for (int k = 0; k < 3000; k++) begin
            logic h, e, x, d, i;
            h = ($urandom % 8) == 0;
            e = ($urandom % 6) == 0;
            x = ($urandom % 5) == 0;
            d = ($urandom % 4) == 0;
            i = ($urandom % 2) == 0;
            cyc("R9", h, e, x, d, i, $urandom, 2'($urandom));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule